// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital control core that sits beside the analog front end of a single-wire LIN bus interface. It reads the enable and transmit-data inputs and selects one of three operating modes: Normal, Silent or Sleep. In Normal mode the transmit input drives the bus driver control and the sampled bus level is passed to the receive output. In Silent and Sleep modes both paths are shut off. In Sleep mode the regulator-enable output is also dropped. The TXD level at the moment the enable falls decides which of the two low-power modes is entered.

A protection timer watches the transmit line. If it stays dominant for too long, the driver is forced recessive. It stays forced until the transmit input has been recessive for a minimum continuous time. A debounced, active-low wake input brings the block out of Sleep into Silent mode. From Silent mode, a high enable moves it to Normal. A separate input produces a registered watchdog-disable flag.

All timing uses a microsecond tick made by a parameterised prescaler. The dominant limit, the clear window and the wake debounce length are parameters counted in ticks.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `mode_o` is Silent (code 0), `rxd_o` is 1, `drv_dom_o` is 0 and `reg_en_o` is 1.
- R2: In Silent mode (code 0), `en_i` high moves `mode_o` to Normal (code 1) at the next clock edge. In Normal mode, `drv_dom_o` equals the inverse of `txd_i` and `rxd_o` equals `bus_i`, each one edge later.
- R3: In Normal mode, `en_i` low while `txd_i` is 1 moves `mode_o` to Silent (code 0) at the next edge. From the following edge, `reg_en_o` is 1, `rxd_o` is 1 and `drv_dom_o` is 0, whatever `bus_i` and `txd_i` are.
- R4: In Normal mode, `en_i` low while `txd_i` is 0 moves `mode_o` to Sleep (code 2) at the next edge. From the following edge, `reg_en_o` is 0, `rxd_o` is 1 and `drv_dom_o` is 0.
- R5: In Normal mode, once `txd_i` has been 0 for DOM_TICKS ticks, `drv_dom_o` goes to 0. It stays 0 while `txd_i` remains 0. It is never 1 unless `txd_i` was 0 in the cycle before.
- R6: A latched timeout clears only after `txd_i` has been 1 for CLR_TICKS consecutive ticks. A shorter recessive period leaves `drv_dom_o` at 0 when `txd_i` returns to 0.
- R7: In Sleep mode, `wake_n_i` low for WAKE_TICKS consecutive ticks moves `mode_o` to Silent with `reg_en_o` 1. A shorter low pulse leaves the block in Sleep. Sleep is left only towards Silent.
- R8: After a wake-up, `en_i` high moves `mode_o` from Silent to Normal at the next edge.
- R9: `wd_dis_o` equals the value `wd_mode_i` had one edge earlier. A value of 1 means the watchdog is disabled.
- R10: In Sleep mode, `en_i` has no effect: `mode_o` stays Sleep (code 2) and `reg_en_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Interface enable |
| txd_i | input | 1 | Transmit data (0 = dominant) |
| bus_i | input | 1 | Sampled bus level (0 = dominant) |
| wake_n_i | input | 1 | Local wake request, active low |
| wd_mode_i | input | 1 | Watchdog-off request |
| drv_dom_o | output | 1 | 1 = bus driver pulls dominant |
| rxd_o | output | 1 | Received bus level |
| reg_en_o | output | 1 | Regulator enable |
| wd_dis_o | output | 1 | Watchdog disabled flag |
| mode_o | output | 2 | Current mode: 0 Silent, 1 Normal, 2 Sleep |

## Verification
The mode register changes one edge after an enable or wake decision. `drv_dom_o`, `rxd_o` and `reg_en_o` are registered from that mode, so they follow one edge later again. The bench therefore checks `mode_o` one cycle after a stimulus and the path outputs two cycles after it. All samples are taken one time unit after a rising edge.

Tick-based results depend on the prescaler phase, which can shift them by up to one tick. For these, the bench checks on both sides of the window: once at least two ticks before the limit can be reached, and again at least two ticks after it must have been reached.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    LM_SILENT = 2'd0,
    LM_NORMAL = 2'd1,
    LM_SLEEP  = 2'd2
  } lin_mode_e;
endpackage

// File: rtl/lin_tick_gen.sv
module lin_tick_gen #(
  parameter int TICK_DIV = 250
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_dom_timeout.sv
module lin_dom_timeout #(
  parameter int DOM_TICKS = 6000,
  parameter int CLR_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic arm_i,
  input  logic txd_i,
  output logic latch_o
);
  localparam int DW = $clog2(DOM_TICKS + 1);
  localparam int RW = $clog2(CLR_TICKS + 1);
  localparam logic [DW-1:0] DOM_LAST = DW'(DOM_TICKS - 1);
  localparam logic [RW-1:0] CLR_LAST = RW'(CLR_TICKS - 1);

  logic [DW-1:0] dom_cnt_q;
  logic [RW-1:0] rec_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dom_cnt_q <= '0;
      rec_cnt_q <= '0;
      latch_o   <= 1'b0;
    end else if (!latch_o) begin
      rec_cnt_q <= '0;
      if (!arm_i || txd_i) begin
        dom_cnt_q <= '0;
      end else if (tick_i) begin
        if (dom_cnt_q == DOM_LAST) begin
          latch_o   <= 1'b1;
          dom_cnt_q <= '0;
        end else begin
          dom_cnt_q <= dom_cnt_q + 1'b1;
        end
      end
    end else begin
      dom_cnt_q <= '0;
      if (!txd_i) begin
        rec_cnt_q <= '0;
      end else if (tick_i) begin
        if (rec_cnt_q == CLR_LAST) begin
          latch_o   <= 1'b0;
          rec_cnt_q <= '0;
        end else begin
          rec_cnt_q <= rec_cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
  parameter int WAKE_TICKS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic wake_n_i,
  output logic wake_evt_o
);
  localparam int WW = $clog2(WAKE_TICKS + 1);
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_TICKS - 1);
  localparam logic [WW-1:0] WAKE_FULL = WW'(WAKE_TICKS);

  logic [WW-1:0] low_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt_q  <= '0;
      wake_evt_o <= 1'b0;
    end else begin
      wake_evt_o <= 1'b0;
      if (wake_n_i) begin
        low_cnt_q <= '0;
      end else if (tick_i && low_cnt_q != WAKE_FULL) begin
        low_cnt_q <= low_cnt_q + 1'b1;
        if (low_cnt_q == WAKE_LAST) wake_evt_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int TICK_DIV   = 250,
  parameter int DOM_TICKS  = 6000,
  parameter int CLR_TICKS  = 10,
  parameter int WAKE_TICKS = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       bus_i,
  input  logic       wake_n_i,
  input  logic       wd_mode_i,
  output logic       drv_dom_o,
  output logic       rxd_o,
  output logic       reg_en_o,
  output logic       wd_dis_o,
  output logic [1:0] mode_o
);
  lin_mode_e state_q, state_d;
  logic      tick;
  logic      to_latch;
  logic      wake_evt;

  lin_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  lin_dom_timeout #(.DOM_TICKS(DOM_TICKS), .CLR_TICKS(CLR_TICKS)) u_dom (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .arm_i   (state_q == LM_NORMAL),
    .txd_i   (txd_i),
    .latch_o (to_latch)
  );

  lin_wake_filter #(.WAKE_TICKS(WAKE_TICKS)) u_wake (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .wake_n_i   (wake_n_i),
    .wake_evt_o (wake_evt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LM_NORMAL: if (!en_i) state_d = txd_i ? LM_SILENT : LM_SLEEP;
      LM_SILENT: if (en_i)  state_d = LM_NORMAL;
      LM_SLEEP:  if (wake_evt) state_d = LM_SILENT;
      default:   state_d = LM_SILENT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= LM_SILENT;
      drv_dom_o <= 1'b0;
      rxd_o     <= 1'b1;
      reg_en_o  <= 1'b1;
    end else begin
      state_q   <= state_d;
      drv_dom_o <= (state_q == LM_NORMAL) && !txd_i && !to_latch;
      rxd_o     <= (state_q == LM_NORMAL) ? bus_i : 1'b1;
      reg_en_o  <= (state_q != LM_SLEEP);
    end
  end

  always_ff @(posedge clk) wd_dis_o <= wd_mode_i;

  assign mode_o = state_q;
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       txd_i,
  input logic       wd_mode_i,
  input logic       drv_dom_o,
  input logic       rxd_o,
  input logic       reg_en_o,
  input logic       wd_dis_o,
  input logic [1:0] mode_o
);
  // R2: dominant drive only out of Normal mode
  a_r2_drv_only_normal: assert property (@(posedge clk) disable iff (rst)
    drv_dom_o |-> ($past(mode_o) == 2'd1));

  // R3: receive path parked high outside Normal
  a_r3_rxd_idle_high: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'd1) |=> rxd_o);

  // R4: regulator off in Sleep
  a_r4_sleep_reg_off: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2) |=> !reg_en_o);

  // R4: Sleep entered only from Normal with TXD low
  a_r4_sleep_entry: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> ($past(mode_o) == 2'd1 && !$past(txd_i)));

  // R5: no dominant drive without dominant TXD the cycle before
  a_r5_drv_needs_txd: assert property (@(posedge clk) disable iff (rst)
    drv_dom_o |-> !$past(txd_i));

  // R7: Sleep is left only to Silent
  a_r7_sleep_exit_silent: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_o) == 2'd2 && mode_o != 2'd2) |-> (mode_o == 2'd0));

  // R9: watchdog flag tracks its input
  a_r9_wd_flag: assert property (@(posedge clk) disable iff (rst)
    wd_dis_o == $past(wd_mode_i));
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .txd_i     (txd_i),
  .wd_mode_i (wd_mode_i),
  .drv_dom_o (drv_dom_o),
  .rxd_o     (rxd_o),
  .reg_en_o  (reg_en_o),
  .wd_dis_o  (wd_dis_o),
  .mode_o    (mode_o)
);

// File: tb/lin_mode_ctrl_tb.sv
module lin_mode_ctrl_tb;
  localparam int DIV  = 4;
  localparam int DOM  = 20;
  localparam int CLR  = 5;
  localparam int WAKE = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, txd = 1'b1, bus = 1'b1, wake_n = 1'b1, wdm = 1'b0;
  logic drv, rxd, reg_en, wd_dis;
  logic [1:0] mode;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lin_mode_ctrl #(.TICK_DIV(DIV), .DOM_TICKS(DOM), .CLR_TICKS(CLR), .WAKE_TICKS(WAKE)) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .txd_i(txd), .bus_i(bus), .wake_n_i(wake_n),
    .wd_mode_i(wdm), .drv_dom_o(drv), .rxd_o(rxd), .reg_en_o(reg_en),
    .wd_dis_o(wd_dis), .mode_o(mode)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; cyc(3);
    chk("R1 mode in reset", mode, 2'd0);
    rst = 1'b0; cyc(1);
    chk("R1 mode", mode, 2'd0);
    chk("R1 rxd", {1'b0, rxd}, 2'd1);
    chk("R1 drv", {1'b0, drv}, 2'd0);
    chk("R1 reg_en", {1'b0, reg_en}, 2'd1);
  endtask

  task automatic t_normal;
    en = 1'b1; txd = 1'b1; bus = 1'b1; cyc(1);
    chk("R2 mode normal", mode, 2'd1);
    txd = 1'b0; bus = 1'b0; cyc(2);
    chk("R2 drv follows txd low", {1'b0, drv}, 2'd1);
    chk("R2 rxd follows bus low", {1'b0, rxd}, 2'd0);
    txd = 1'b1; bus = 1'b1; cyc(2);
    chk("R2 drv follows txd high", {1'b0, drv}, 2'd0);
    chk("R2 rxd follows bus high", {1'b0, rxd}, 2'd1);
  endtask

  task automatic t_silent;
    en = 1'b0; cyc(1);
    chk("R3 mode silent", mode, 2'd0);
    txd = 1'b0; bus = 1'b0; cyc(2);
    chk("R3 drv recessive", {1'b0, drv}, 2'd0);
    chk("R3 rxd high", {1'b0, rxd}, 2'd1);
    chk("R3 reg_en", {1'b0, reg_en}, 2'd1);
    txd = 1'b1; bus = 1'b1; en = 1'b1; cyc(1);
    chk("R2 back to normal", mode, 2'd1);
  endtask

  task automatic t_timeout;
    txd = 1'b0; cyc((DOM - 2) * DIV);
    chk("R5 drv before limit", {1'b0, drv}, 2'd1);
    cyc(4 * DIV);
    chk("R5 drv forced recessive", {1'b0, drv}, 2'd0);
    txd = 1'b1; cyc((CLR - 2) * DIV);
    txd = 1'b0; cyc(2);
    chk("R6 short recessive keeps latch", {1'b0, drv}, 2'd0);
    txd = 1'b1; cyc((CLR + 2) * DIV);
    txd = 1'b0; cyc(2);
    chk("R6 latch cleared", {1'b0, drv}, 2'd1);
    txd = 1'b1; cyc(2);
  endtask

  task automatic t_sleep;
    txd = 1'b0; en = 1'b0; bus = 1'b0; cyc(1);
    chk("R4 mode sleep", mode, 2'd2);
    cyc(1);
    chk("R4 reg_en off", {1'b0, reg_en}, 2'd0);
    chk("R4 rxd high", {1'b0, rxd}, 2'd1);
    chk("R4 drv recessive", {1'b0, drv}, 2'd0);
    en = 1'b1; cyc(10);
    chk("R10 en ignored mode", mode, 2'd2);
    chk("R10 en ignored reg_en", {1'b0, reg_en}, 2'd0);
    en = 1'b0; txd = 1'b1; bus = 1'b1; cyc(1);
  endtask

  task automatic t_wake;
    wake_n = 1'b0; cyc((WAKE - 2) * DIV);
    wake_n = 1'b1; cyc(2);
    chk("R7 short wake ignored", mode, 2'd2);
    wake_n = 1'b0; cyc((WAKE + 2) * DIV);
    chk("R7 woke to silent", mode, 2'd0);
    chk("R7 reg_en on", {1'b0, reg_en}, 2'd1);
    wake_n = 1'b1; en = 1'b1; cyc(1);
    chk("R8 normal after wake", mode, 2'd1);
  endtask

  task automatic t_wd;
    wdm = 1'b1; cyc(1);
    chk("R9 wd disabled", {1'b0, wd_dis}, 2'd1);
    wdm = 1'b0; cyc(1);
    chk("R9 wd enabled", {1'b0, wd_dis}, 2'd0);
  endtask

  initial begin
    t_reset;
    t_normal;
    t_silent;
    t_timeout;
    t_sleep;
    t_wake;
    t_wd;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule